// File: doc/BRIEF.md
# Receive-Only Parallel Printer Port

This block is the receiving end of a PC-style parallel printer link. An external sender places a byte on eight data lines and pulls an active-low strobe. The port passes the strobe through a flip-flop synchroniser and captures the byte on the synchronised falling edge. It then holds the busy line high until host software has taken the byte. When software releases busy, the port answers with a fixed-length active-low acknowledge pulse.

The host sees a small register window of four word slots, selected by a two-bit address:
- The data slot returns the captured byte. Reading it consumes the byte.
- The status slot reports whether a byte is waiting, the synchronised strobe level and the busy line.
- The control slot holds an interrupt enable and a busy override. It also holds three printer-status outputs (paper-empty, selected, fault) that software drives directly.

A level-sensitive interrupt is raised while a byte is waiting and the interrupt enable is set. Consuming the byte drops it.

Top module: `lprx_port`

## Requirements
- R1: After reset, busy, interrupt, paper-empty, selected and fault are low and acknowledge is high. The status slot (address 1) reads 0x02 and the control slot (address 2) reads 0x00.
- R2: A high-to-low strobe, after the synchroniser, captures the data lines into the data slot and sets the byte-waiting flag (status bit 0).
- R3: Busy is high whenever a byte is waiting. Status bit 2 mirrors the busy output.
- R4: A read of the data slot (address 0) returns the captured byte. On the following clock the byte-waiting flag clears and the automatic busy drops.
- R5: When a read consumes a waiting byte, acknowledge goes low for exactly ACK_CYCLES clocks, starting on the clock of the read. A data read with no byte waiting produces no pulse.
- R6: The interrupt output is high exactly while a byte is waiting and control bit 0 (interrupt enable) is set. It is a level, not a pulse.
- R7: Control bit 1 forces busy high independently of the byte-waiting flag. Consuming a byte while forced still produces the acknowledge pulse.
- R8: Control bits 2, 3 and 4 drive fault, selected and paper-empty directly. Control bits 7:5 are not stored and read back as 0.
- R9: Status bit 1 reports the synchronised strobe level. Writes to the data and status slots change nothing. Address 3 reads 0.
- R10: A new strobe while a byte is still waiting overwrites the byte and leaves the flag set. A strobe edge in the same clock as a data read wins, so the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access valid this clock |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Slot: 0 data, 1 status, 2 control, 3 none |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (combinational) |
| lpt_strobe_n | input | 1 | Sender strobe, active low, asynchronous |
| lpt_data | input | DATA_W | Sender data lines |
| lpt_busy | output | 1 | Busy back to sender |
| lpt_ack_n | output | 1 | Acknowledge pulse, active low |
| lpt_paper_out | output | 1 | Paper-empty output (control bit 4) |
| lpt_select | output | 1 | Selected output (control bit 3) |
| lpt_fault | output | 1 | Fault output (control bit 2) |
| irq | output | 1 | Level interrupt to host |

## Verification
A lost or stuck byte-waiting flag shows at once on the busy pin and in status bit 0. It also shows on the interrupt line whenever the enable is set, so a flag that fails to clear after a data read is visible on the next clock. A wrong acknowledge counter shows as a pulse one clock too short or too long, or as a pulse after an empty read. The bench measures the pulse length clock by clock. A synchroniser with the wrong depth or edge sense shows up in two ways: no byte is captured, or the status strobe bit disagrees with a held-low strobe within a few clocks.

// File: rtl/lprx_pkg.sv
// Shared definitions for the receive-only parallel port: register slot
// codes, control register layout and status bit positions.
package lprx_pkg;

    // Register slot selected by the two address bits
    typedef enum logic [1:0] {
        SLOT_DATA = 2'd0,
        SLOT_STAT = 2'd1,
        SLOT_CTRL = 2'd2,
        SLOT_NONE = 2'd3
    } slot_e;

    // Control register, packed with irq_en at bit 0
    typedef struct packed {
        logic paper;       // bit 4
        logic select;      // bit 3
        logic fault;       // bit 2
        logic force_busy;  // bit 1
        logic irq_en;      // bit 0
    } ctrl_t;

    localparam int CTRL_BITS = $bits(ctrl_t);

    // Status bit positions
    localparam int ST_READY  = 0;
    localparam int ST_STROBE = 1;
    localparam int ST_BUSY   = 2;

endpackage

// File: rtl/lprx_strobe_sync.sv
// Multi-stage synchroniser for the asynchronous active-low strobe.
// Assumes: STAGES >= 2 and strobe pulses longer than STAGES+1 clocks.
// Provides the synchronised level and a one-clock falling-edge pulse.
module lprx_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic level,
    output logic fall
);
    localparam int LAST = STAGES - 1;

    logic [STAGES:0] shreg;

    // Shift the raw strobe through the synchroniser plus one history stage
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '1;
        else        shreg <= {shreg[STAGES-1:0], strobe_n};
    end

    assign level = shreg[LAST];
    assign fall  = shreg[STAGES] & ~shreg[LAST];

endmodule

// File: rtl/lprx_capture.sv
// Byte latch and byte-waiting flag.
// Assumes: sender data is stable while the synchronised edge is taken.
// A strobe edge in the same clock as a consuming read wins.
module lprx_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall,
    input  logic              rd_data,
    input  logic [DATA_W-1:0] lpt_data,
    output logic [DATA_W-1:0] byte_q,
    output logic              ready,
    output logic              release_p
);

    // Capture the data lines on each synchronised strobe edge
    always_ff @(posedge clk) begin
        if (!rst_n)    byte_q <= '0;
        else if (fall) byte_q <= lpt_data;
    end

    // Set the flag on an edge; clear it when software consumes the byte
    always_ff @(posedge clk) begin
        if (!rst_n)       ready <= 1'b0;
        else if (fall)    ready <= 1'b1;
        else if (rd_data) ready <= 1'b0;
    end

    // Automatic busy release: a consuming read of a waiting byte
    assign release_p = rd_data & ready & ~fall;

    AST_READY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> ready);  // R2
    AST_BYTE_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(byte_q));  // R2
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !fall) |=> !ready);  // R4
    AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && fall) |=> ready);  // R10

endmodule

// File: rtl/lprx_ack_gen.sv
// Fixed-width active-low acknowledge pulse generator.
// Assumes: ACK_CYCLES >= 1. A start during a pulse restarts it.
module lprx_ack_gen #(
    parameter int ACK_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ack_n
);
    localparam int CW = $clog2(ACK_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(ACK_CYCLES);

    logic [CW-1:0] cnt;
    logic [CW-1:0] low_run;

    // Load on start, count down to zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= LOAD;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign ack_n = (cnt == '0);

    // Checker: length of the current low run, restarted by each start
    always_ff @(posedge clk) begin
        if (!rst_n)              low_run <= '0;
        else if (ack_n || start) low_run <= '0;
        else if (low_run != LOAD) low_run <= low_run + 1'b1;
    end

    AST_ACK_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !ack_n);  // R5
    AST_ACK_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |-> (low_run < LOAD));  // R5

endmodule

// File: rtl/lprx_regs.sv
// Host register window: control register storage, read multiplexer and
// the data-read strobe. Reads are combinational; side effects land on
// the clock edge of the access.
module lprx_regs #(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [1:0]            bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    input  logic [DATA_W-1:0]     byte_q,
    input  logic                  ready,
    input  logic                  strobe_lvl,
    input  logic                  busy,
    output lprx_pkg::ctrl_t       ctrl,
    output logic                  rd_data,
    output logic                  wr_ctrl,
    output logic [DATA_W-1:0]     rdata
);
    import lprx_pkg::*;

    slot_e slot;
    logic [DATA_W-1:0] status_w;

    assign slot    = slot_e'(bus_addr);
    assign rd_data = bus_sel & ~bus_wr & (slot == SLOT_DATA);
    assign wr_ctrl = bus_sel &  bus_wr & (slot == SLOT_CTRL);

    // Store the implemented control bits on a control write
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl <= '0;
        else if (wr_ctrl) ctrl <= ctrl_t'(bus_wdata[CTRL_BITS-1:0]);
    end

    // Assemble the status word
    always_comb begin
        status_w            = '0;
        status_w[ST_READY]  = ready;
        status_w[ST_STROBE] = strobe_lvl;
        status_w[ST_BUSY]   = busy;
    end

    // Select the addressed slot for a read
    always_comb begin
        rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (slot)
                SLOT_DATA: rdata = byte_q;
                SLOT_STAT: rdata = status_w;
                SLOT_CTRL: rdata = {{(DATA_W-CTRL_BITS){1'b0}}, ctrl};
                default:   rdata = '0;
            endcase
        end
    end

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(ctrl));  // R9

endmodule

// File: rtl/lprx_port.sv
// Receive-only parallel printer port, top level.
// Wires the strobe synchroniser, byte latch, acknowledge generator and
// register window. Assumes DATA_W >= 5 so the control word fits.
module lprx_port #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int ACK_CYCLES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              lpt_strobe_n,
    input  logic [DATA_W-1:0] lpt_data,
    output logic              lpt_busy,
    output logic              lpt_ack_n,
    output logic              lpt_paper_out,
    output logic              lpt_select,
    output logic              lpt_fault,
    output logic              irq
);
    import lprx_pkg::*;

    logic              strobe_lvl, fall;
    logic              rd_data, wr_ctrl, ready, release_p;
    logic [DATA_W-1:0] byte_q;
    ctrl_t             ctrl;

    lprx_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .strobe_n(lpt_strobe_n),
        .level(strobe_lvl), .fall(fall)
    );

    lprx_capture #(.DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .fall(fall), .rd_data(rd_data),
        .lpt_data(lpt_data), .byte_q(byte_q), .ready(ready),
        .release_p(release_p)
    );

    lprx_ack_gen #(.ACK_CYCLES(ACK_CYCLES)) u_ack (
        .clk(clk), .rst_n(rst_n), .start(release_p), .ack_n(lpt_ack_n)
    );

    lprx_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .byte_q(byte_q),
        .ready(ready), .strobe_lvl(strobe_lvl), .busy(lpt_busy),
        .ctrl(ctrl), .rd_data(rd_data), .wr_ctrl(wr_ctrl), .rdata(bus_rdata)
    );

    // Sender-facing outputs
    assign lpt_busy      = ready | ctrl.force_busy;
    assign lpt_paper_out = ctrl.paper;
    assign lpt_select    = ctrl.select;
    assign lpt_fault     = ctrl.fault;
    assign irq           = ready & ctrl.irq_en;

    AST_BUSY_WHILE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> lpt_busy);  // R3
    AST_FORCE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.force_busy |-> lpt_busy);  // R7
    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !rd_data && !wr_ctrl) |=> irq);  // R6

endmodule

// File: tb/sim_lprx_port.sv
`timescale 1ns/1ps
module sim_lprx_port;
    localparam int DW  = 8;
    localparam int ACK = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0]    bus_addr = 2'd0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          lpt_strobe_n = 1'b1;
    logic [DW-1:0] lpt_data = '0;
    logic          lpt_busy, lpt_ack_n, lpt_paper_out, lpt_select, lpt_fault, irq;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lprx_port #(.DATA_W(DW), .SYNC_STAGES(2), .ACK_CYCLES(ACK)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .lpt_strobe_n(lpt_strobe_n), .lpt_data(lpt_data), .lpt_busy(lpt_busy),
        .lpt_ack_n(lpt_ack_n), .lpt_paper_out(lpt_paper_out),
        .lpt_select(lpt_select), .lpt_fault(lpt_fault), .irq(irq)
    );

    // Stimulus table: bit 8 = interrupt enable, bits 7:0 = byte sent
    localparam logic [8:0] VEC [0:5] = '{9'h1A5, 9'h03C, 9'h1FF, 9'h000, 9'h15A, 9'h081};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic send_byte(input logic [DW-1:0] b);
        @(negedge clk);
        lpt_data = b; lpt_strobe_n = 1'b0;
        repeat (5) @(negedge clk);
        lpt_strobe_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // Count clocks of acknowledge low, starting at the negedge after the read
    task automatic ack_len(output int n);
        n = 0;
        for (int i = 0; i < 20; i++) begin
            if (lpt_ack_n !== 1'b0) break;
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        logic [DW-1:0] d;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", lpt_busy, 0);
        chk("R1 ack_n", lpt_ack_n, 1);
        chk("R1 irq", irq, 0);
        chk("R1 status outs", {lpt_paper_out, lpt_select, lpt_fault}, 0);
        bus_read(2'd1, d); chk("R1 status", d, 8'h02);
        bus_read(2'd2, d); chk("R1 ctrl", d, 8'h00);

        // Table walk: R2 R3 R4 R5 R6
        foreach (VEC[i]) begin
            bus_write(2'd2, {7'd0, VEC[i][8]});
            send_byte(VEC[i][7:0]);
            chk("R6 irq level", irq, VEC[i][8]);
            chk("R3 busy", lpt_busy, 1);
            bus_read(2'd1, d); chk("R2 R3 status", d, 8'h07);
            bus_read(2'd0, d); chk("R4 data", d, VEC[i][7:0]);
            ack_len(n); chk("R5 ack width", n, ACK);
            chk("R4 busy released", lpt_busy, 0);
            chk("R6 irq cleared", irq, 0);
            bus_read(2'd1, d); chk("R4 status", d, 8'h02);
        end

        // R5: empty read gives no pulse
        bus_read(2'd0, d);
        chk("R5 no ack on empty read", lpt_ack_n, 1);
        @(negedge clk); chk("R5 no ack later", lpt_ack_n, 1);

        // R8 R7: control outputs and forced busy
        bus_write(2'd2, 8'hFE);
        chk("R8 paper", lpt_paper_out, 1);
        chk("R8 select", lpt_select, 1);
        chk("R8 fault", lpt_fault, 1);
        chk("R7 forced busy", lpt_busy, 1);
        bus_read(2'd2, d); chk("R8 ctrl readback", d, 8'h1E);
        bus_read(2'd1, d); chk("R7 status busy", d, 8'h06);
        send_byte(8'h33);
        bus_read(2'd0, d); chk("R7 data", d, 8'h33);
        chk("R7 ack while forced", lpt_ack_n, 0);
        chk("R7 busy stays forced", lpt_busy, 1);
        repeat (6) @(negedge clk);
        bus_write(2'd2, 8'h14);
        chk("R8 fault only b2", {lpt_paper_out, lpt_select, lpt_fault}, 3'b101);
        bus_write(2'd2, 8'h00);
        chk("R8 outputs cleared", {lpt_paper_out, lpt_select, lpt_fault, lpt_busy}, 0);

        // R9: ignored writes and empty slot
        send_byte(8'h5C);
        bus_write(2'd0, 8'hFF);
        bus_write(2'd1, 8'h00);
        bus_read(2'd1, d); chk("R9 status unchanged", d, 8'h07);
        bus_read(2'd3, d); chk("R9 addr3", d, 8'h00);
        bus_read(2'd0, d); chk("R9 data unchanged", d, 8'h5C);
        repeat (6) @(negedge clk);

        // R10 overwrite, R9 strobe level
        send_byte(8'h11);
        @(negedge clk);
        lpt_data = 8'h22; lpt_strobe_n = 1'b0;
        repeat (5) @(negedge clk);
        bus_read(2'd1, d); chk("R9 strobe low in status", d, 8'h05);
        lpt_strobe_n = 1'b1;
        repeat (4) @(negedge clk);
        bus_read(2'd0, d); chk("R10 overwrite", d, 8'h22);
        repeat (6) @(negedge clk);
        bus_read(2'd1, d); chk("R10 status after", d, 8'h02);

        // R6: enabling after arrival raises the level
        send_byte(8'h77);
        chk("R6 irq disabled", irq, 0);
        bus_write(2'd2, 8'h01);
        chk("R6 irq after enable", irq, 1);
        bus_read(2'd0, d);
        chk("R6 irq after read", irq, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog all actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule